// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data path of an eight-line general purpose I/O port. Each line is either an input or an output, chosen by a direction register. Input pin levels pass through a one-stage register and are then copied into the data register. Output lines drive the data register bit. An input line with a fixed pull resistor drives the pull level. An input line with no pull floats and keeps the last level it reported.

Software reaches the data register through a 1 KiB window. In that window, byte address bits [9:2] act as a per-bit mask. A read returns only the selected bits. A write changes only the selected bits, and only on output lines. Single bits can therefore be set or cleared atomically, with no read-modify-write sequence. The direction register sits directly above the window. Each output line also has a one-cycle change indication that marks the cycle in which its resolved level changes.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the direction register is 0 (all inputs) and the data register is 0. pin_out equals the pull-up mask, with pulled-down and floating lines at 0, and out_chg is 0.
- R2: A byte address below 0x400 (bits [11:10] both 0) selects the data register. Address bits [9:2] give an 8-bit mask in which bit 2 of the address masks line 0.
- R3: A data read returns the data register ANDed with the address mask, so every unmasked bit reads as 0.
- R4: A data write updates a line's data bit only when that line is set both in the address mask and in the direction register. All other data bits are unchanged.
- R5: For an input line, the data register bit takes the level pin_in had two clock edges earlier. The first edge captures the pin and the second edge updates the data register.
- R6: The direction register is at byte address 0x400. It is 8 bits wide, 1 means output, and it reads back what was last written.
- R7: An output line drives its data register bit on pin_out, one clock edge after the data or direction register changes.
- R8: An input line in the pull-up mask drives 1 and an input line in the pull-down mask drives 0, whatever its pin level.
- R9: An input line with neither pull keeps the last value it drove on pin_out.
- R10: out_chg bit i is high for exactly the one cycle in which pin_out bit i has just changed, and it is 0 otherwise.
- R11: Any other address ignores writes and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as a read strobe |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Resolved line levels |
| out_chg | output | 8 | Per-line one-cycle change pulse |

## Verification
Read data is combinational, so the bench samples it 1 ns after it sets a read strobe on a falling edge. A register write takes effect on the next rising edge. pin_out and out_chg follow one rising edge after that, so the bench checks them at the second falling edge after the write strobe. A pin_in change reaches the data register after two rising edges. The bench reads the data register after one edge to confirm the old value is still present, and again after the second edge to see the new one. Every stimulus is driven and every output sampled on the falling edge, away from the active edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register targeted by a bus access
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_target_e;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12
) (
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  output acc_target_e          target,
  output logic [NUM_LINES-1:0] addr_mask,
  output logic                 data_wr,
  output logic                 dir_wr
);

  localparam int WIN_BITS = NUM_LINES + 2;
  localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << WIN_BITS;

  logic in_window;
  logic unused_addr_lo;

  function automatic acc_target_e decode_target(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:WIN_BITS] == '0) return ACC_DATA;
    else if (a == DIR_OFF)          return ACC_DIR;
    else                            return ACC_NONE;
  endfunction

  assign unused_addr_lo = ^bus_addr[1:0];
  assign in_window      = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
  assign target         = decode_target(bus_addr);
  assign addr_mask      = bus_addr[WIN_BITS-1:2];
  assign data_wr        = bus_en && bus_we && (target == ACC_DATA);
  assign dir_wr         = bus_en && bus_we && (target == ACC_DIR);

  always_comb begin
    assert (!(in_window && target != ACC_DATA)) else $error("window decode mismatch"); // R2
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_LINES = 8,
  parameter int STAGES    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_q
);

  logic [NUM_LINES-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign pin_q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dir_wr,
  input  logic                 data_wr,
  input  logic [NUM_LINES-1:0] wr_mask,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] pin_q,
  output logic [NUM_LINES-1:0] dir_q,
  output logic [NUM_LINES-1:0] data_q
);

  // Bits a data write may change: masked by address and limited to outputs
  logic [NUM_LINES-1:0] wr_bits;
  logic [NUM_LINES-1:0] data_next;

  function automatic logic [NUM_LINES-1:0] merge_data(
    input logic [NUM_LINES-1:0] cur,
    input logic [NUM_LINES-1:0] dir,
    input logic [NUM_LINES-1:0] wbits,
    input logic [NUM_LINES-1:0] wval,
    input logic [NUM_LINES-1:0] pins
  );
    return (pins & ~dir) | (cur & dir & ~wbits) | (wval & wbits);
  endfunction

  assign wr_bits   = data_wr ? (wr_mask & dir_q) : '0;
  assign data_next = merge_data(data_q, dir_q, wr_bits, wdata, pin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (dir_wr) dir_q <= wdata;
      data_q <= data_next;
    end
  end

  AST_IN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q & ~$past(dir_q)) == ($past(pin_q) & ~$past(dir_q)))); // R5
  AST_WR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wr_bits)) == '0)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q)); // R6
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (dir_q == $past(wdata))); // R6

endmodule

// File: rtl/gpio_out_resolve.sv
module gpio_out_resolve #(
  parameter int                   NUM_LINES   = 8,
  parameter logic [NUM_LINES-1:0] PULLUP_MASK = '1,
  parameter logic [NUM_LINES-1:0] PULLDN_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] dir_q,
  input  logic [NUM_LINES-1:0] data_q,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] out_chg
);

  logic [NUM_LINES-1:0] out_q;
  logic [NUM_LINES-1:0] chg_q;
  logic [NUM_LINES-1:0] out_next;
  logic [NUM_LINES-1:0] up_in;
  logic [NUM_LINES-1:0] dn_in;
  logic [NUM_LINES-1:0] float_in;

  // Output first, then pull-up, then pull-down, else hold
  function automatic logic resolve_line(
    input logic is_out, input logic dbit, input logic up,
    input logic dn, input logic prev
  );
    if (is_out)  return dbit;
    else if (up) return 1'b1;
    else if (dn) return 1'b0;
    else         return prev;
  endfunction

  assign up_in    = PULLUP_MASK & ~dir_q;
  assign dn_in    = PULLDN_MASK & ~PULLUP_MASK & ~dir_q;
  assign float_in = ~(PULLUP_MASK | PULLDN_MASK) & ~dir_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign out_next[i] = resolve_line(dir_q[i], data_q[i], PULLUP_MASK[i],
                                      PULLDN_MASK[i], out_q[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[i] <= PULLUP_MASK[i];
        chg_q[i] <= 1'b0;
      end else begin
        out_q[i] <= out_next[i];
        chg_q[i] <= out_next[i] ^ out_q[i];
      end
    end
  end

  assign pin_out = out_q;
  assign out_chg = chg_q;

  AST_OUT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_q & $past(dir_q)) == ($past(data_q) & $past(dir_q)))); // R7
  AST_PULL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_q & $past(up_in)) == $past(up_in))); // R8
  AST_PULL_DN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_q & $past(dn_in)) == '0)); // R8
  AST_FLOAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((out_q ^ $past(out_q)) & $past(float_in)) == '0)); // R9
  AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chg_q == (out_q ^ $past(out_q)))); // R10

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_port_pkg::*;
#(
  parameter int                   NUM_LINES   = 8,
  parameter int                   ADDR_W      = 12,
  parameter int                   SYNC_STAGES = 1,
  parameter logic [NUM_LINES-1:0] PULLUP_MASK = '1,
  parameter logic [NUM_LINES-1:0] PULLDN_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] out_chg
);

  acc_target_e          target;
  logic [NUM_LINES-1:0] addr_mask;
  logic                 data_wr;
  logic                 dir_wr;
  logic [NUM_LINES-1:0] pin_q;
  logic [NUM_LINES-1:0] dir_q;
  logic [NUM_LINES-1:0] data_q;
  logic                 rd_strobe;

  gpio_bus_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_decode (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .target    (target),
    .addr_mask (addr_mask),
    .data_wr   (data_wr),
    .dir_wr    (dir_wr)
  );

  gpio_in_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .pin_q  (pin_q)
  );

  gpio_data_reg #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_wr  (dir_wr),
    .data_wr (data_wr),
    .wr_mask (addr_mask),
    .wdata   (bus_wdata),
    .pin_q   (pin_q),
    .dir_q   (dir_q),
    .data_q  (data_q)
  );

  gpio_out_resolve #(
    .NUM_LINES  (NUM_LINES),
    .PULLUP_MASK(PULLUP_MASK),
    .PULLDN_MASK(PULLDN_MASK)
  ) u_resolve (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_q   (dir_q),
    .data_q  (data_q),
    .pin_out (pin_out),
    .out_chg (out_chg)
  );

  assign rd_strobe = bus_en && !bus_we;

  always_comb begin
    bus_rdata = '0;
    if (rd_strobe) begin
      unique case (target)
        ACC_DATA: bus_rdata = data_q & addr_mask;
        ACC_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && target == ACC_DATA) |-> ((bus_rdata & ~addr_mask) == '0)); // R3
  AST_RD_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && target == ACC_NONE) |-> (bus_rdata == '0)); // R11
  AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/gpio_masked_port_tb.sv
`timescale 1ns/1ps
module gpio_masked_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  out_chg;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Lines 0-3 pulled up, 4-5 pulled down, 6-7 floating
  localparam logic [7:0] PU = 8'h0F;
  localparam logic [7:0] PD = 8'h30;

  always #5 clk = ~clk;

  gpio_masked_port #(.PULLUP_MASK(PU), .PULLDN_MASK(PD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .out_chg(out_chg)
  );

  function automatic logic [11:0] maddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_in = '0; bus_en = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    apply_reset();
    chk("R1 pin_out", pin_out, PU);
    chk("R1 out_chg", out_chg, 8'h00);
    bus_read(12'h400, r); chk("R1 dir", r, 8'h00);
    bus_read(12'h3FC, r); chk("R1 data", r, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] r;
    apply_reset();
    bus_write(12'h400, 8'hA5);
    bus_read(12'h400, r); chk("R6 dir readback", r, 8'hA5);
    @(negedge clk);
    chk("R7 pin_out outputs low", pin_out, 8'h0A);
    chk("R10 pulse on fall", out_chg, 8'h05);
    @(negedge clk);
    chk("R10 pulse one cycle", out_chg, 8'h00);
  endtask

  task automatic t_input();
    logic [7:0] r;
    apply_reset();
    pin_in = 8'h5A;
    @(negedge clk);
    bus_read(12'h3FC, r); chk("R5 not yet", r, 8'h00);
    @(negedge clk);
    bus_read(12'h3FC, r); chk("R5 follows pin", r, 8'h5A);
    chk("R8 inputs do not drive", pin_out, PU);
  endtask

  task automatic t_read_mask();
    logic [7:0] r;
    apply_reset();
    pin_in = 8'hB6;
    repeat (2) @(negedge clk);
    bus_read(maddr(8'hFF), r); chk("R3 full mask", r, 8'hB6);
    bus_read(maddr(8'h0F), r); chk("R3 low mask", r, 8'h06);
    bus_read(maddr(8'hF0), r); chk("R3 high mask", r, 8'hB0);
    bus_read(maddr(8'h00), r); chk("R2 zero mask", r, 8'h00);
    bus_read(maddr(8'h80), r); chk("R2 bit7 mask", r, 8'h80);
  endtask

  task automatic t_write_mask();
    logic [7:0] r;
    apply_reset();
    bus_write(12'h400, 8'h3C);
    bus_write(maddr(8'h0F), 8'hFF);
    bus_read(12'h3FC, r); chk("R4 mask and dir", r, 8'h0C);
    @(negedge clk);
    chk("R7 drive", pin_out, 8'h0F);
    chk("R10 rise pulse", out_chg, 8'h0C);
    bus_write(maddr(8'h04), 8'h00);
    @(negedge clk);
    chk("R4 single bit clear", pin_out, 8'h0B);
    chk("R10 single pulse", out_chg, 8'h04);
    bus_write(maddr(8'h01), 8'hFF);
    bus_read(12'h3FC, r); chk("R4 input bit untouched", r, 8'h08);
  endtask

  task automatic t_pulls();
    apply_reset();
    bus_write(12'h400, 8'h30);
    bus_write(maddr(8'h30), 8'hFF);
    @(negedge clk);
    chk("R7 pull-down lines driven high", pin_out, 8'h3F);
    bus_write(12'h400, 8'h00);
    @(negedge clk);
    chk("R8 pull-down", pin_out, 8'h0F);
    chk("R10 fall pulse", out_chg, 8'h30);
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R8 pins ignored", pin_out, 8'h0F);
  endtask

  task automatic t_float();
    apply_reset();
    bus_write(12'h400, 8'hC0);
    bus_write(maddr(8'hC0), 8'hFF);
    @(negedge clk);
    chk("R7 float lines driven", pin_out, 8'hCF);
    bus_write(12'h400, 8'h00);
    @(negedge clk);
    chk("R9 hold after release", pin_out, 8'hCF);
    chk("R10 no pulse on hold", out_chg, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 hold with pin low", pin_out, 8'hCF);
    bus_write(12'h400, 8'h40);
    @(negedge clk);
    chk("R7 data from pin", pin_out, 8'h8F);
    chk("R10 line6 pulse", out_chg, 8'h40);
  endtask

  task automatic t_other();
    logic [7:0] r;
    apply_reset();
    bus_write(12'h404, 8'hFF);
    bus_read(12'h400, r); chk("R11 dir untouched", r, 8'h00);
    bus_read(12'h404, r); chk("R11 read zero", r, 8'h00);
    bus_write(12'h800, 8'hFF);
    bus_read(12'h800, r); chk("R11 high addr zero", r, 8'h00);
    @(negedge clk);
    chk("R11 pin_out unchanged", pin_out, PU);
    bus_read(12'h3FC, r); chk("R11 data unchanged", r, 8'h00);
  endtask

  initial begin
    t_reset();
    t_dir();
    t_input();
    t_read_mask();
    t_write_mask();
    t_pulls();
    t_float();
    t_other();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule